// File: doc/BRIEF.md
# Quad Chip-Select Command Register

This block is the clocked capture stage for the address/command path of a memory module that carries four ranks. Each rising clock edge reads the four active-low chip selects and sorts the pattern into one of four classes. A valid selection latches the address/command bus and passes the chip-select pattern through. An idle cycle drives all chip-select outputs high and either keeps the bus or floats it. The control-word pattern leaves the bus untouched and raises a strobe for an internal register file. Every other pattern is rejected as illegal. The on-die-termination and clock-enable lanes are captured on every edge, whatever the chip selects say.

Floating is modelled by output-enable flags, not by tri-state drivers. The bus value stays in its register while the bus is floated. Whether an idle cycle floats the bus depends on a configuration input. A three-cycle command timing mode input overrides that configuration and always keeps the bus driven.

Top module: `qcs_cmd_reg`

## Requirements
- R1: While `rst_n` is low, `cmd_oe`, `cs_oe`, `odt_oe`, `cw_strobe` and `cs_illegal` are 0, `cke_q` is all zeros and `cs_q` is 4'b1111, with no clock needed. `cmd_q` resets to zero.
- R2: A chip-select pattern with exactly one bit low loads `cmd_in` into `cmd_q` on the edge and copies the pattern to `cs_q`. It also sets `cmd_oe` to 1.
- R3: The paired-low patterns 4'b0101, 4'b1001, 4'b0110 and 4'b1010 (bit 3 is the leftmost) behave as in R2.
- R4: The pattern 4'b0011 (selects 3 and 2 low) leaves `cmd_q`, `cmd_oe` and `cs_q` unchanged. It sets `cw_strobe` to 1 for the following cycle only.
- R5: The pattern 4'b1111 sets `cs_q` to 4'b1111. When `cfg_float_idle` is 0, it keeps `cmd_q` and `cmd_oe` unchanged.
- R6: The pattern 4'b1111 with `cfg_float_idle`=1 and `mode_3t`=0 clears `cmd_oe` and keeps `cmd_q` unchanged.
- R7: The pattern 4'b1111 with `mode_3t`=1 keeps `cmd_q` and `cmd_oe` unchanged, whatever the value of `cfg_float_idle`.
- R8: Out of reset, every edge loads `odt_in` into `odt_q` and `cke_in` into `cke_q` and sets `odt_oe` and `cs_oe` to 1, for any chip-select pattern.
- R9: Any pattern with three or four bits low, and any pattern with bits 1 and 0 both low, leaves `cmd_q`, `cmd_oe` and `cs_q` unchanged. It sets `cs_illegal` to 1 for the following cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; everything is sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| cs_n | input | 4 | Active-low chip selects, bit 3 to bit 0 |
| cmd_in | input | BUS_W (23) | Address/command bus |
| odt_in | input | LANES (2) | On-die-termination lane inputs |
| cke_in | input | LANES (2) | Clock-enable lane inputs |
| cfg_float_idle | input | 1 | Idle cycles float the bus when set |
| mode_3t | input | 1 | Three-cycle timing mode active; disables idle floating |
| cmd_q | output | BUS_W (23) | Registered address/command bus |
| cmd_oe | output | 1 | Bus driven (1) or floated (0) |
| cs_q | output | 4 | Registered chip-select pattern |
| cs_oe | output | 1 | Chip-select outputs driven |
| odt_q | output | LANES (2) | Registered termination lanes |
| odt_oe | output | 1 | Termination outputs driven |
| cke_q | output | LANES (2) | Registered clock-enable lanes |
| cw_strobe | output | 1 | Control-word access seen on the previous edge |
| cs_illegal | output | 1 | Illegal chip-select pattern seen on the previous edge |

## Verification
The hardest case to reach is an idle cycle whose outcome depends on the bus state left by earlier cycles. One example is a floated bus followed by a control-word or illegal pattern, which must keep it floated. Another is the three-cycle mode forcing a hold while the float configuration is set. The directed phase builds these chains on purpose: capture, float, then a non-capturing pattern, then a capture that must re-enable the bus. A long random phase then mixes all sixteen patterns with both configuration inputs and occasional mid-run resets. A behavioural reference model checks every output on every cycle.

// File: rtl/qcs_pkg.sv
`timescale 1ns/1ps
package qcs_pkg;
  localparam int unsigned CS_CNT = 4;
  localparam logic [CS_CNT-1:0] CS_CTRL_PAT = 4'b0011;
  localparam logic [CS_CNT-1:0] CS_IDLE_PAT = 4'b1111;

  typedef enum logic [1:0] {
    CLS_CAPTURE = 2'd0,
    CLS_IDLE    = 2'd1,
    CLS_CTRL    = 2'd2,
    CLS_ILLEGAL = 2'd3
  } qcs_cls_e;
endpackage

// File: rtl/qcs_decode.sv
`timescale 1ns/1ps
module qcs_decode
  import qcs_pkg::*;
(
  input  logic [CS_CNT-1:0] cs_n,
  output qcs_cls_e          cls
);
  localparam int unsigned CNT_W = $clog2(CS_CNT + 1);

  logic [CNT_W-1:0] low_cnt;

  always_comb begin
    low_cnt = '0;
    for (int i = 0; i < CS_CNT; i++) begin
      low_cnt = low_cnt + CNT_W'(~cs_n[i]);
    end
  end

  always_comb begin
    unique case (low_cnt)
      CNT_W'(0): cls = CLS_IDLE;
      CNT_W'(1): cls = CLS_CAPTURE;
      CNT_W'(2): begin
        if (cs_n == CS_CTRL_PAT)      cls = CLS_CTRL;
        else if (cs_n[1:0] == 2'b00)  cls = CLS_ILLEGAL;
        else                          cls = CLS_CAPTURE;
      end
      default:   cls = CLS_ILLEGAL;
    endcase
  end
endmodule

// File: rtl/qcs_bus_reg.sv
`timescale 1ns/1ps
module qcs_bus_reg
  import qcs_pkg::*;
#(
  parameter int unsigned BUS_W = 23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  qcs_cls_e          cls,
  input  logic [CS_CNT-1:0] cs_n,
  input  logic [BUS_W-1:0]  cmd_in,
  input  logic              cfg_float_idle,
  input  logic              mode_3t,
  output logic [BUS_W-1:0]  cmd_q,
  output logic              cmd_oe,
  output logic [CS_CNT-1:0] cs_q,
  output logic              cs_oe,
  output logic              cw_strobe,
  output logic              cs_illegal
);
  logic              cmd_en;
  logic [BUS_W-1:0]  cmd_d;
  logic              oe_d;
  logic [CS_CNT-1:0] cs_d;
  logic              float_ok;

  assign float_ok = cfg_float_idle & ~mode_3t;

  always_comb begin
    cmd_en = (cls == CLS_CAPTURE);
    cmd_d  = cmd_in;
    oe_d   = cmd_oe;
    cs_d   = cs_q;
    unique case (cls)
      CLS_CAPTURE: begin
        oe_d = 1'b1;
        cs_d = cs_n;
      end
      CLS_IDLE: begin
        cs_d = CS_IDLE_PAT;
        if (float_ok) oe_d = 1'b0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
    end else if (cmd_en) begin
      cmd_q <= cmd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_oe     <= 1'b0;
      cs_q       <= CS_IDLE_PAT;
      cs_oe      <= 1'b0;
      cw_strobe  <= 1'b0;
      cs_illegal <= 1'b0;
    end else begin
      cmd_oe     <= oe_d;
      cs_q       <= cs_d;
      cs_oe      <= 1'b1;
      cw_strobe  <= (cls == CLS_CTRL);
      cs_illegal <= (cls == CLS_ILLEGAL);
    end
  end
endmodule

// File: rtl/qcs_lane_reg.sv
`timescale 1ns/1ps
module qcs_lane_reg #(
  parameter int unsigned LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] odt_in,
  input  logic [LANES-1:0] cke_in,
  output logic [LANES-1:0] odt_q,
  output logic             odt_oe,
  output logic [LANES-1:0] cke_q
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        odt_q[g] <= 1'b0;
        cke_q[g] <= 1'b0;
      end else begin
        odt_q[g] <= odt_in[g];
        cke_q[g] <= cke_in[g];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) odt_oe <= 1'b0;
    else        odt_oe <= 1'b1;
  end
endmodule

// File: rtl/qcs_cmd_reg.sv
`timescale 1ns/1ps
module qcs_cmd_reg
  import qcs_pkg::*;
#(
  parameter int unsigned BUS_W = 23,
  parameter int unsigned LANES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CS_CNT-1:0] cs_n,
  input  logic [BUS_W-1:0]  cmd_in,
  input  logic [LANES-1:0]  odt_in,
  input  logic [LANES-1:0]  cke_in,
  input  logic              cfg_float_idle,
  input  logic              mode_3t,
  output logic [BUS_W-1:0]  cmd_q,
  output logic              cmd_oe,
  output logic [CS_CNT-1:0] cs_q,
  output logic              cs_oe,
  output logic [LANES-1:0]  odt_q,
  output logic              odt_oe,
  output logic [LANES-1:0]  cke_q,
  output logic              cw_strobe,
  output logic              cs_illegal
);
  qcs_cls_e cls;

  qcs_decode u_dec (
    .cs_n (cs_n),
    .cls  (cls)
  );

  qcs_bus_reg #(.BUS_W(BUS_W)) u_bus (
    .clk            (clk),
    .rst_n          (rst_n),
    .cls            (cls),
    .cs_n           (cs_n),
    .cmd_in         (cmd_in),
    .cfg_float_idle (cfg_float_idle),
    .mode_3t        (mode_3t),
    .cmd_q          (cmd_q),
    .cmd_oe         (cmd_oe),
    .cs_q           (cs_q),
    .cs_oe          (cs_oe),
    .cw_strobe      (cw_strobe),
    .cs_illegal     (cs_illegal)
  );

  qcs_lane_reg #(.LANES(LANES)) u_lane (
    .clk    (clk),
    .rst_n  (rst_n),
    .odt_in (odt_in),
    .cke_in (cke_in),
    .odt_q  (odt_q),
    .odt_oe (odt_oe),
    .cke_q  (cke_q)
  );
endmodule

// File: rtl/qcs_cmd_reg_chk.sv
`timescale 1ns/1ps
module qcs_cmd_reg_chk #(
  parameter int unsigned BUS_W = 23,
  parameter int unsigned LANES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       cs_n,
  input logic [BUS_W-1:0] cmd_in,
  input logic [LANES-1:0] odt_in,
  input logic [LANES-1:0] cke_in,
  input logic             cfg_float_idle,
  input logic             mode_3t,
  input logic [BUS_W-1:0] cmd_q,
  input logic             cmd_oe,
  input logic [3:0]       cs_q,
  input logic             cs_oe,
  input logic [LANES-1:0] odt_q,
  input logic             odt_oe,
  input logic [LANES-1:0] cke_q,
  input logic             cw_strobe,
  input logic             cs_illegal
);
  logic bad_pat;
  assign bad_pat = ($countones(~cs_n) >= 3) || (cs_n[1:0] == 2'b00);

  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst_n)
    1'b1 |-> (!cmd_oe && !cs_oe && !odt_oe && cke_q == '0 && !cw_strobe && !cs_illegal));

  p_single_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(~cs_n) == 1) |=> (cmd_q == $past(cmd_in) && cs_q == $past(cs_n) && cmd_oe));

  p_pair_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n == 4'b0101 || cs_n == 4'b1001 || cs_n == 4'b0110 || cs_n == 4'b1010)
    |=> (cmd_q == $past(cmd_in) && cs_q == $past(cs_n) && cmd_oe));

  p_ctrl_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n == 4'b0011) |=> (cw_strobe && $stable(cmd_q) && $stable(cmd_oe) && $stable(cs_q)));

  p_idle_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n == 4'b1111) |=> (cs_q == 4'b1111));

  p_idle_float_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n == 4'b1111 && cfg_float_idle && !mode_3t) |=> (!cmd_oe && $stable(cmd_q)));

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n == 4'b1111 && (!cfg_float_idle || mode_3t)) |=> ($stable(cmd_oe) && $stable(cmd_q)));

  p_lanes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (odt_q == $past(odt_in) && cke_q == $past(cke_in) && odt_oe && cs_oe));

  p_illegal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bad_pat |=> (cs_illegal && $stable(cmd_q) && $stable(cmd_oe) && $stable(cs_q)));
endmodule

bind qcs_cmd_reg qcs_cmd_reg_chk #(.BUS_W(BUS_W), .LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cmd_in(cmd_in), .odt_in(odt_in),
  .cke_in(cke_in), .cfg_float_idle(cfg_float_idle), .mode_3t(mode_3t),
  .cmd_q(cmd_q), .cmd_oe(cmd_oe), .cs_q(cs_q), .cs_oe(cs_oe), .odt_q(odt_q),
  .odt_oe(odt_oe), .cke_q(cke_q), .cw_strobe(cw_strobe), .cs_illegal(cs_illegal)
);

// File: tb/qcs_cmd_reg_tb_top.sv
`timescale 1ns/1ps
module qcs_cmd_reg_tb_top;
  localparam int BW = 23;
  localparam int NL = 2;

  logic          clk;
  logic          rst_n;
  logic [3:0]    cs_n;
  logic [BW-1:0] cmd_in;
  logic [NL-1:0] odt_in, cke_in;
  logic          cfg_float_idle, mode_3t;
  logic [BW-1:0] cmd_q;
  logic          cmd_oe, cs_oe, odt_oe, cw_strobe, cs_illegal;
  logic [3:0]    cs_q;
  logic [NL-1:0] odt_q, cke_q;

  int checks = 0;
  int errors = 0;

  qcs_cmd_reg #(.BUS_W(BW), .LANES(NL)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cmd_in(cmd_in), .odt_in(odt_in),
    .cke_in(cke_in), .cfg_float_idle(cfg_float_idle), .mode_3t(mode_3t),
    .cmd_q(cmd_q), .cmd_oe(cmd_oe), .cs_q(cs_q), .cs_oe(cs_oe), .odt_q(odt_q),
    .odt_oe(odt_oe), .cke_q(cke_q), .cw_strobe(cw_strobe), .cs_illegal(cs_illegal)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Behavioural reference model
  logic [BW-1:0] m_cmd;
  logic          m_oe, m_cs_oe, m_odt_oe, m_stb, m_ill;
  logic [3:0]    m_cs;
  logic [NL-1:0] m_odt, m_cke;
  string         m_tag;

  function automatic int lows_of(input logic [3:0] v);
    int n = 0;
    for (int i = 0; i < 4; i++) if (v[i] == 1'b0) n++;
    return n;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cmd <= '0; m_oe <= 1'b0; m_cs <= 4'hF; m_cs_oe <= 1'b0;
      m_odt <= '0; m_odt_oe <= 1'b0; m_cke <= '0;
      m_stb <= 1'b0; m_ill <= 1'b0; m_tag <= "R1";
    end else begin
      int n;
      n = lows_of(cs_n);
      m_odt <= odt_in; m_cke <= cke_in; m_odt_oe <= 1'b1; m_cs_oe <= 1'b1;
      m_stb <= 1'b0; m_ill <= 1'b0;
      if (n == 0) begin
        m_cs <= 4'hF;
        if (cfg_float_idle && !mode_3t) begin m_oe <= 1'b0; m_tag <= "R6"; end
        else if (mode_3t)               m_tag <= "R7";
        else                            m_tag <= "R5";
      end else if (n == 1) begin
        m_cmd <= cmd_in; m_cs <= cs_n; m_oe <= 1'b1; m_tag <= "R2";
      end else if (n == 2 && cs_n == 4'b0011) begin
        m_stb <= 1'b1; m_tag <= "R4";
      end else if (n == 2 && cs_n[1:0] != 2'b00) begin
        m_cmd <= cmd_in; m_cs <= cs_n; m_oe <= 1'b1; m_tag <= "R3";
      end else begin
        m_ill <= 1'b1; m_tag <= "R9";
      end
    end
  end

  task automatic cmp(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_all();
    cmp(m_tag, "cmd_q", 32'(cmd_q), 32'(m_cmd));
    cmp(m_tag, "cmd_oe", 32'(cmd_oe), 32'(m_oe));
    cmp(m_tag, "cs_q", 32'(cs_q), 32'(m_cs));
    cmp(m_tag, "cw_strobe", 32'(cw_strobe), 32'(m_stb));
    cmp(m_tag, "cs_illegal", 32'(cs_illegal), 32'(m_ill));
    cmp((m_tag == "R1") ? "R1" : "R8", "cs_oe", 32'(cs_oe), 32'(m_cs_oe));
    cmp((m_tag == "R1") ? "R1" : "R8", "odt_oe", 32'(odt_oe), 32'(m_odt_oe));
    cmp((m_tag == "R1") ? "R1" : "R8", "odt_q", 32'(odt_q), 32'(m_odt));
    cmp((m_tag == "R1") ? "R1" : "R8", "cke_q", 32'(cke_q), 32'(m_cke));
  endtask

  // check the previous edge's results, then apply the next stimulus
  task automatic step(input logic rst, input logic [3:0] cs, input logic cfg,
                      input logic m3t);
    @(negedge clk);
    check_all();
    rst_n          = rst;
    cs_n           = cs;
    cmd_in         = BW'($urandom);
    odt_in         = NL'($urandom);
    cke_in         = NL'($urandom);
    cfg_float_idle = cfg;
    mode_3t        = m3t;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b1; cs_n = 4'hF; cmd_in = '0; odt_in = '1; cke_in = '1;
    cfg_float_idle = 1'b0; mode_3t = 1'b0;
    #1 rst_n = 1'b0;
    // R1: reset state held over several edges with busy inputs
    step(1'b0, 4'b1110, 1'b1, 1'b0);
    step(1'b0, 4'b1110, 1'b1, 1'b0);
    // R5: idle right after reset keeps bus floated and cs high
    step(1'b1, 4'hF, 1'b0, 1'b0);
    // R2: each single-low pattern
    step(1'b1, 4'b1110, 1'b0, 1'b0);
    step(1'b1, 4'b1101, 1'b0, 1'b0);
    step(1'b1, 4'b1011, 1'b0, 1'b0);
    step(1'b1, 4'b0111, 1'b0, 1'b0);
    // R3: the four accepted pairs
    step(1'b1, 4'b0101, 1'b0, 1'b0);
    step(1'b1, 4'b1001, 1'b0, 1'b0);
    step(1'b1, 4'b0110, 1'b0, 1'b0);
    step(1'b1, 4'b1010, 1'b0, 1'b0);
    // R4: control-word access, twice back to back
    step(1'b1, 4'b0011, 1'b1, 1'b0);
    step(1'b1, 4'b0011, 1'b0, 1'b0);
    // R5 hold, R7 override, R6 float
    step(1'b1, 4'hF, 1'b0, 1'b0);
    step(1'b1, 4'hF, 1'b1, 1'b1);
    step(1'b1, 4'hF, 1'b1, 1'b0);
    // floated bus must stay floated through ctrl/illegal (R4, R9)
    step(1'b1, 4'b0011, 1'b0, 1'b0);
    step(1'b1, 4'b1100, 1'b0, 1'b0);
    // R9: every illegal pattern
    step(1'b1, 4'b0000, 1'b0, 1'b0);
    step(1'b1, 4'b0001, 1'b0, 1'b0);
    step(1'b1, 4'b0010, 1'b0, 1'b0);
    step(1'b1, 4'b0100, 1'b0, 1'b0);
    step(1'b1, 4'b1000, 1'b0, 1'b0);
    // R2: capture re-enables the bus
    step(1'b1, 4'b1101, 1'b1, 1'b0);
    step(1'b1, 4'hF, 1'b0, 1'b1);
    // random mix, R8 lanes checked every cycle, occasional reset (R1)
    for (int k = 0; k < 4000; k++) begin
      step(($urandom_range(0, 199) != 0), 4'($urandom), 1'($urandom), 1'($urandom));
    end
    step(1'b1, 4'hF, 1'b0, 1'b0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule